// File: doc/BRIEF.md
# Half-Bridge Non-Overlap Drive Sequencer

This block takes a single PWM pulse train from a voltage-mode controller and turns it into four enables for gate drivers. Two enables drive the high-side and low-side primary switches of a half bridge. Two enables drive the secondary synchronous rectifiers. Accepted pulses go to the two primary switches in turn. Switching always starts on the low side, so that the bootstrap capacitor of the high-side driver charges first.

A dead-time counter separates each primary switch from its related rectifier. The rectifier enable drops first. The primary switch turns on only after the programmed count has run out. When the primary switch turns off, the rectifier enable returns only after the same count. Between pulses both rectifier enables are high, which turns both rectifiers on. A line over-range flag holds off the high side. A run enable stops switching at once and restores low-side-first ordering.

Top module: `hbs_sequencer`

## Requirements
- R1: While reset is held and after reset is released, `gate_hi` and `gate_lo` are 0, `sr_hi_en` and `sr_lo_en` are 1, and the first accepted pulse goes to the low side.
- R2: A pulse is accepted only on a rising edge of `pwm_in` that is seen while the sequencer is idle and `run_en` is 1. Accepted pulses that reach conduction alternate between low, high, low and so on. The low side is always first after reset, and first again after `run_en` has been low.
- R3: Let D be the value of `dead_cnt` sampled in the cycle of the rising edge. The related rectifier enable (`sr_lo_en` for the low side, `sr_hi_en` for the high side) falls in the cycle after that edge. The primary gate rises exactly D+1 cycles after the rectifier enable falls.
- R4: After a primary gate falls, its related rectifier enable rises again exactly D+1 cycles later.
- R5: Between pulses both primary gates are 0 and both rectifier enables are 1.
- R6: `gate_hi` and `gate_lo` are never 1 together. Neither gate is 1 while both rectifier enables are 1.
- R7: Let N be the number of consecutive clock samples in which `pwm_in` is 1, starting with the rising-edge sample. If N is D+1 or less, the pulse is dropped. No gate rises, the rectifier enable is restored, and the alternation phase does not advance.
- R8: If N is greater than D+1, the primary gate stays high for exactly N-D-1 cycles.
- R9: While `hs_inhibit` is 1, `gate_hi` is 0 from the next cycle on. A high-side turn that comes while the flag is set is skipped, and the next accepted pulse goes to the low side. The high side resumes in turn after the flag clears.
- R10: When `run_en` is 0, both gates are 0 from the next cycle on. The next accepted pulse after `run_en` returns goes to the low side.
- R11: A change on `dead_cnt` after the rising-edge cycle has no effect on the lead or trail delay of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Switching enable |
| pwm_in | input | 1 | PWM pulse train from the modulator |
| dead_cnt | input | DT_W | Dead time in clock cycles (D) |
| hs_inhibit | input | 1 | Line over-range flag, holds off the high side |
| gate_hi | output | 1 | High-side primary switch enable |
| gate_lo | output | 1 | Low-side primary switch enable |
| sr_hi_en | output | 1 | Enable of the rectifier related to the high side |
| sr_lo_en | output | 1 | Enable of the rectifier related to the low side |

## Verification
The bench builds the block with the default DT_W of 6. This lets it drive the dead count at both extremes: zero, where the lead and trail gaps are one cycle, and 63, where each gap is 64 cycles. The same width lets it change the dead count in the middle of a pulse, to show that the value latched at the rising edge is kept. Pulse lengths are chosen to land exactly on the drop boundary of D+1 samples and just above it. The stimulus also raises the inhibit flag and drops the run enable while a gate is conducting.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_ON    = 2'd2,
        ST_TRAIL = 2'd3
    } hbs_state_e;

    localparam logic SIDE_LO = 1'b0;
    localparam logic SIDE_HI = 1'b1;

    typedef struct packed {
        hbs_state_e state;
        logic       side;
        logic       phase;
        logic       stop;
        logic       pwm_prev;
    } hbs_seq_t;

endpackage

// File: rtl/hbs_dead_timer.sv
module hbs_dead_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/hbs_drive_map.sv
module hbs_drive_map
    import hbs_pkg::*;
(
    input  hbs_state_e state,
    input  logic       side,
    output logic [1:0] gate,
    output logic [1:0] sr_en
);
    for (genvar s = 0; s < 2; s++) begin : g_side
        logic mine;
        assign mine     = (side == 1'(s));
        assign gate[s]  = (state == ST_ON) && mine;
        assign sr_en[s] = !((state != ST_IDLE) && mine);
    end
endmodule

// File: rtl/hbs_sequencer.sv
module hbs_sequencer
    import hbs_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dead_cnt,
    input  logic            hs_inhibit,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            sr_hi_en,
    output logic            sr_lo_en
);
    hbs_seq_t        seq_d, seq_q;
    logic [DT_W-1:0] dt_d, dt_q;
    logic            tmr_load;
    logic [DT_W-1:0] tmr_val;
    logic            tmr_busy;
    logic            pwm_rise;
    logic            hi_blocked;
    logic [1:0]      gate_v;
    logic [1:0]      sr_v;

    hbs_dead_timer #(.W(DT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .busy     (tmr_busy)
    );

    assign pwm_rise   = pwm_in && !seq_q.pwm_prev;
    assign hi_blocked = hs_inhibit && (seq_q.side == SIDE_HI);

    always_comb begin
        seq_d          = seq_q;
        dt_d           = dt_q;
        tmr_load       = 1'b0;
        tmr_val        = dead_cnt;
        seq_d.pwm_prev = pwm_in;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (!run_en) begin
                    seq_d.phase = SIDE_LO;
                end else if (pwm_rise) begin
                    if ((seq_q.phase == SIDE_HI) && hs_inhibit) begin
                        seq_d.phase = SIDE_LO;
                    end else begin
                        seq_d.state = ST_LEAD;
                        seq_d.side  = seq_q.phase;
                        seq_d.stop  = 1'b0;
                        dt_d        = dead_cnt;
                        tmr_load    = 1'b1;
                        tmr_val     = dead_cnt;
                    end
                end
            end
            ST_LEAD: begin
                if (!run_en) begin
                    seq_d.state = ST_IDLE;
                    seq_d.phase = SIDE_LO;
                end else if (!pwm_in) begin
                    seq_d.state = ST_IDLE;
                end else if (hi_blocked) begin
                    seq_d.state = ST_IDLE;
                    seq_d.phase = SIDE_LO;
                end else if (!tmr_busy) begin
                    seq_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (!run_en) begin
                    seq_d.stop = 1'b1;
                end
                if (!run_en || !pwm_in || hi_blocked) begin
                    seq_d.state = ST_TRAIL;
                    tmr_load    = 1'b1;
                    tmr_val     = dt_q;
                end
            end
            ST_TRAIL: begin
                if (!run_en) begin
                    seq_d.stop = 1'b1;
                end
                if (!tmr_busy) begin
                    seq_d.state = ST_IDLE;
                    if (run_en && !seq_q.stop) begin
                        seq_d.phase = !seq_q.side;
                    end else begin
                        seq_d.phase = SIDE_LO;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, side: SIDE_LO, phase: SIDE_LO,
                       stop: 1'b0, pwm_prev: 1'b0};
            dt_q  <= '0;
        end else begin
            seq_q <= seq_d;
            dt_q  <= dt_d;
        end
    end

    hbs_drive_map u_map (
        .state (seq_q.state),
        .side  (seq_q.side),
        .gate  (gate_v),
        .sr_en (sr_v)
    );

    assign gate_lo  = gate_v[0];
    assign gate_hi  = gate_v[1];
    assign sr_lo_en = sr_v[0];
    assign sr_hi_en = sr_v[1];
endmodule

// File: rtl/hbs_seq_checker.sv
module hbs_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic hs_inhibit,
    input logic gate_hi,
    input logic gate_lo,
    input logic sr_hi_en,
    input logic sr_lo_en
);
    assert_gate_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    assert_sr_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi || gate_lo) |-> !(sr_hi_en && sr_lo_en));

    assert_lead_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> !$past(sr_lo_en));

    assert_lead_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(sr_hi_en));

    assert_trail_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_lo_en) |-> !$past(gate_lo));

    assert_trail_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_hi_en) |-> !$past(gate_hi));

    assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !(gate_hi || gate_lo));

    assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_inhibit |=> !gate_hi);
endmodule

bind hbs_sequencer hbs_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .hs_inhibit (hs_inhibit),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .sr_hi_en   (sr_hi_en),
    .sr_lo_en   (sr_lo_en)
);

// File: tb/tb_hbs_sequencer.sv
module tb_hbs_sequencer;
    localparam int DT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic pwm_in = 1'b0;
    logic [DT_W-1:0] dead_cnt = '0;
    logic hs_inhibit = 1'b0;
    logic gate_hi, gate_lo, sr_hi_en, sr_lo_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    hbs_sequencer #(.DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_in(pwm_in),
        .dead_cnt(dead_cnt), .hs_inhibit(hs_inhibit),
        .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sr_hi_en(sr_hi_en), .sr_lo_en(sr_lo_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 waiting, 2 conducting, 3 recovering
    int m_mode = 0, m_side = 0, m_next = 0, m_wait = 0, m_dead = 0;
    bit m_prev = 0, m_halted = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_side = 0; m_next = 0; m_wait = 0; m_dead = 0;
            m_prev = 0; m_halted = 0;
        end else begin
            bit edge_seen;
            edge_seen = pwm_in && !m_prev;
            m_prev = pwm_in;
            if (m_mode == 0) begin
                if (!run_en) m_next = 0;
                else if (edge_seen) begin
                    if (m_next == 1 && hs_inhibit) m_next = 0;
                    else begin
                        m_mode = 1; m_side = m_next; m_dead = int'(dead_cnt);
                        m_wait = m_dead; m_halted = 0;
                    end
                end
            end else if (m_mode == 1) begin
                if (!run_en) begin m_mode = 0; m_next = 0; end
                else if (!pwm_in) m_mode = 0;
                else if (m_side == 1 && hs_inhibit) begin m_mode = 0; m_next = 0; end
                else if (m_wait == 0) m_mode = 2;
                else m_wait--;
            end else if (m_mode == 2) begin
                if (!run_en) m_halted = 1;
                if (!run_en || !pwm_in || (m_side == 1 && hs_inhibit)) begin
                    m_mode = 3; m_wait = m_dead;
                end
            end else begin
                if (!run_en) m_halted = 1;
                if (m_wait == 0) begin
                    m_mode = 0;
                    m_next = (run_en && !m_halted) ? 1 - m_side : 0;
                end else m_wait--;
            end
        end
    end

    // edge-timing monitors
    int lo_cnt = 0, hi_cnt = 0, first_side = -1;
    int lead_gap = 0, on_w = 0, trail_gap = 0, overlap = 0;
    int t_sr_off = 0, t_g_on = 0, t_g_off = 0;
    bit p_glo = 0, p_ghi = 0, p_srlo = 1, p_srhi = 1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit e_glo, e_ghi, e_srlo, e_srhi;
            e_glo  = (m_mode == 2) && (m_side == 0);
            e_ghi  = (m_mode == 2) && (m_side == 1);
            e_srlo = !((m_mode != 0) && (m_side == 0));
            e_srhi = !((m_mode != 0) && (m_side == 1));
            chk({gate_lo, gate_hi, sr_lo_en, sr_hi_en} == {e_glo, e_ghi, e_srlo, e_srhi},
                "cycle model R3 R4 R8", int'({gate_lo, gate_hi, sr_lo_en, sr_hi_en}),
                int'({e_glo, e_ghi, e_srlo, e_srhi}));
            if ((gate_hi && gate_lo) || ((gate_hi || gate_lo) && sr_hi_en && sr_lo_en))
                overlap++;
            if ((p_srlo && !sr_lo_en) || (p_srhi && !sr_hi_en)) t_sr_off = cyc;
            if (!p_glo && gate_lo) begin
                lo_cnt++; lead_gap = cyc - t_sr_off; t_g_on = cyc;
                if (first_side < 0) first_side = 0;
            end
            if (!p_ghi && gate_hi) begin
                hi_cnt++; lead_gap = cyc - t_sr_off; t_g_on = cyc;
                if (first_side < 0) first_side = 1;
            end
            if ((p_glo && !gate_lo) || (p_ghi && !gate_hi)) begin
                on_w = cyc - t_g_on; t_g_off = cyc;
            end
            if ((!p_srlo && sr_lo_en) || (!p_srhi && sr_hi_en)) trail_gap = cyc - t_g_off;
            p_glo = gate_lo; p_ghi = gate_hi; p_srlo = sr_lo_en; p_srhi = sr_hi_en;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int n, input int gap);
        pwm_in = 1'b1;
        step(n);
        pwm_in = 1'b0;
        step(gap);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int lo0, hi0;
        step(3);
        @(negedge clk);
        chk({gate_hi, gate_lo, sr_hi_en, sr_lo_en} == 4'b0011, "R1 in reset",
            int'({gate_hi, gate_lo, sr_hi_en, sr_lo_en}), 3);
        @(posedge clk); #1;
        rst_n = 1'b1; run_en = 1'b1; dead_cnt = 6'd2;
        step(2);
        @(negedge clk);
        chk({gate_hi, gate_lo, sr_hi_en, sr_lo_en} == 4'b0011, "R1 after reset",
            int'({gate_hi, gate_lo, sr_hi_en, sr_lo_en}), 3);
        @(posedge clk); #1;

        // alternation with D=2, N=8
        pulse(8, 12);
        chk(first_side == 0, "R1 first side low", first_side, 0);
        chk(lead_gap == 3, "R3 lead gap D=2", lead_gap, 3);
        chk(on_w == 5, "R8 on width N-D-1", on_w, 5);
        chk(trail_gap == 3, "R4 trail gap D=2", trail_gap, 3);
        pulse(8, 12); pulse(8, 12); pulse(8, 12);
        chk(lo_cnt == 2 && hi_cnt == 2, "R2 alternation lo", lo_cnt, 2);
        chk(hi_cnt == 2, "R2 alternation hi", hi_cnt, 2);
        @(negedge clk);
        chk({gate_hi, gate_lo, sr_hi_en, sr_lo_en} == 4'b0011, "R5 idle level",
            int'({gate_hi, gate_lo, sr_hi_en, sr_lo_en}), 3);
        @(posedge clk); #1;

        // D=0 on the low side
        dead_cnt = 6'd0;
        pulse(4, 8);
        chk(lead_gap == 1, "R3 lead gap D=0", lead_gap, 1);
        chk(trail_gap == 1, "R4 trail gap D=0", trail_gap, 1);
        chk(lo_cnt == 3, "R2 low after pair", lo_cnt, 3);

        // drop boundary: D=4, N=5 dropped, next goes high with N=10
        dead_cnt = 6'd4;
        lo0 = lo_cnt; hi0 = hi_cnt;
        pulse(5, 10);
        chk(lo_cnt == lo0 && hi_cnt == hi0, "R7 short pulse dropped", hi_cnt - hi0, 0);
        chk(sr_hi_en && sr_lo_en, "R7 rectifier restored", int'({sr_hi_en, sr_lo_en}), 3);
        pulse(10, 12);
        chk(hi_cnt == hi0 + 1, "R7 phase not advanced", hi_cnt - hi0, 1);
        chk(on_w == 5, "R8 on width just above drop", on_w, 5);

        // dead count changed mid pulse (low side)
        dead_cnt = 6'd3;
        pwm_in = 1'b1;
        step(1);
        dead_cnt = 6'd10;
        step(8);
        pwm_in = 1'b0;
        step(16);
        chk(lead_gap == 4, "R11 lead uses sampled D", lead_gap, 4);
        chk(trail_gap == 4, "R11 trail uses sampled D", trail_gap, 4);

        // inhibit: high turn skipped, low continues, high resumes
        dead_cnt = 6'd1;
        hs_inhibit = 1'b1;
        lo0 = lo_cnt; hi0 = hi_cnt;
        pulse(6, 10);
        chk(lo_cnt == lo0 && hi_cnt == hi0, "R9 high turn skipped", hi_cnt - hi0, 0);
        pulse(6, 10);
        chk(lo_cnt == lo0 + 1, "R9 low continues", lo_cnt - lo0, 1);
        hs_inhibit = 1'b0;
        pulse(6, 10);
        chk(hi_cnt == hi0 + 1, "R9 high resumes", hi_cnt - hi0, 1);

        // inhibit raised during a high-side conduction
        pulse(6, 10);
        pwm_in = 1'b1;
        step(6);
        chk(gate_hi == 1'b1, "R9 high conducting", int'(gate_hi), 1);
        hs_inhibit = 1'b1;
        step(1);
        @(negedge clk);
        chk(gate_hi == 1'b0, "R9 high cut by flag", int'(gate_hi), 0);
        @(posedge clk); #1;
        pwm_in = 1'b0;
        hs_inhibit = 1'b0;
        step(10);

        // run enable dropped during low-side conduction
        lo0 = lo_cnt;
        pwm_in = 1'b1;
        step(5);
        chk(gate_lo == 1'b1, "R10 low conducting", int'(gate_lo), 1);
        run_en = 1'b0;
        step(1);
        @(negedge clk);
        chk(!gate_lo && !gate_hi, "R10 gates off", int'({gate_hi, gate_lo}), 0);
        @(posedge clk); #1;
        pwm_in = 1'b0;
        step(6);
        run_en = 1'b1;
        step(2);
        pulse(6, 10);
        chk(lo_cnt == lo0 + 2, "R10 restart on low side", lo_cnt - lo0, 2);

        // largest dead count on the high side
        dead_cnt = 6'd63;
        hi0 = hi_cnt;
        pulse(70, 80);
        chk(hi_cnt == hi0 + 1, "R2 high after restart", hi_cnt - hi0, 1);
        chk(lead_gap == 64, "R3 lead gap D=63", lead_gap, 64);
        chk(on_w == 6, "R8 on width D=63", on_w, 6);
        chk(trail_gap == 64, "R4 trail gap D=63", trail_gap, 64);
        chk(overlap == 0, "R6 no overlap seen", overlap, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule